// File: doc/BRIEF.md
# Shadow RAM Write-Protect Gate

This block sits beside the memory controller and judges every memory cycle that the address decoder has tagged as falling inside a shadowed DRAM region. For each cycle it decides whether DRAM may be written, whether the second-level cache may be filled or updated, whether the processor should treat the access as write-through in its internal cache, and whether the processor's internal cache line must be invalidated by an external strobe.

Protection is per region. A write-enable vector holds one bit per shadow region, and the decoder supplies the index of the region that was hit. A protected region refuses ordinary DRAM writes, cache write updates and line fills. The one exception is a writeback of dirty second-level cache data that the controller starts itself. That writeback always reaches DRAM, because its data was legitimately cached while the region was still writable. Two configuration bits tune how the processor is handled. One forces write-through for shadow accesses, so that every processor write appears on the bus while the region can still accept it. The other turns on an invalidate strobe when a processor write hits a protected region.

Every accepted cycle is completed with a ready, including writes that are dropped, so the bus never hangs.

Top module: `shadow_wp_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `dram_we`, `cache_block` and `cyc_ready` are 0 and `cpu_inval_n` is 1.
- R2: A cycle of kind write (`cyc_kind` = 2'b01) from the processor, to a shadowed region whose `region_we_vec[region_idx]` bit is 0, gives `dram_we` = 0 and `cache_block` = 1 in the clock after the strobe.
- R3: A read cycle (`cyc_kind` 2'b00, or the spare code 2'b11, which is treated as a read) to a protected shadowed region gives `cache_block` = 1 and `dram_we` = 0 in the clock after the strobe, so no line fill happens.
- R4: A second-level writeback (`cyc_kind` = 2'b10) gives `dram_we` = 1 and `cache_block` = 0 in the clock after the strobe, whatever the region's protection.
- R5: `cpu_force_wt` equals `cyc_strobe & shadow_hit & cfg_force_wt` combinationally, in the same clock as the strobe.
- R6: `cpu_inval_n` goes low for exactly the clock after a strobe whose cycle is a processor write to a protected shadowed region while `cfg_inval_en` is 1. At all other times it is 1.
- R7: A write to a shadowed region whose write-enable bit is 1 gives `dram_we` = 1 and `cache_block` = 0 in the clock after the strobe, whether or not write-through is being forced.
- R8: `cyc_ready` is 1 in exactly the clock after each strobe, including strobes for dropped writes.
- R9: When `shadow_hit` is 0, the cycle passes through: `dram_we` follows whether the cycle is a write or a writeback, `cache_block` is 0, and `cpu_inval_n` stays 1.
- R10: A protected write that does not come from the processor (`cyc_from_cpu` = 0) is blocked like R2 but never pulses `cpu_inval_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_strobe | input | 1 | Address strobe, one clock per cycle |
| cyc_kind | input | 2 | 00 read, 01 write, 10 second-level writeback, 11 read |
| cyc_from_cpu | input | 1 | Cycle was started by the processor |
| shadow_hit | input | 1 | Address lies in a shadow region |
| region_idx | input | SEL_W (3) | Index of the region that was hit |
| region_we_vec | input | REGIONS (8) | Per-region write enable, 1 = writable |
| cfg_force_wt | input | 1 | Force processor write-through on shadow accesses |
| cfg_inval_en | input | 1 | Enable the invalidate strobe on protected processor writes |
| dram_we | output | 1 | DRAM write permitted for the cycle (registered) |
| cache_block | output | 1 | Inhibit line fill and cache write update (registered) |
| cpu_force_wt | output | 1 | Write-through request to the processor (combinational) |
| cpu_inval_n | output | 1 | Active-low invalidate strobe to the processor |
| cyc_ready | output | 1 | Cycle completion (registered) |

## Verification
On every clock, the in-line assertions check that a ready follows each strobe, that writebacks always write DRAM, that protected writes are blocked, that unshadowed cycles pass through unchanged, and that an invalidate pulse only follows a protected processor write with the enable set. Only the bench's scenarios show the rest. These are the reset values, the same-clock write-through request, writable writes succeeding under forced write-through, non-processor writes going without an invalidate, and the interaction of back-to-back cycles with changing region protection and configuration bits. The bench compares every output each clock against its own behavioural model.

// File: rtl/swp_pkg.sv
// Shared types for the shadow RAM write-protect gate.
// Assumes a two-bit cycle kind. The spare code is treated as a read.
package swp_pkg;

    typedef enum logic [1:0] {
        CYC_READ  = 2'b00,
        CYC_WRITE = 2'b01,
        CYC_L2WB  = 2'b10,
        CYC_SPARE = 2'b11
    } cyc_kind_e;

    // Per-cycle verdict, produced combinationally and registered once.
    typedef struct packed {
        logic dram_we;
        logic cache_block;
        logic inval_req;
        logic ready;
    } gate_dec_t;

endpackage

// File: rtl/swp_region_sel.sv
// Picks the write-enable bit of the region that was hit.
// Assumes region_idx is only meaningful while shadow_hit is set. An index
// beyond REGIONS-1 is treated as writable, so that it never blocks a cycle.
module swp_region_sel #(
    parameter int REGIONS = 8,
    localparam int SEL_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
    input  logic [SEL_W-1:0]   region_idx,
    input  logic [REGIONS-1:0] region_we_vec,
    output logic               region_writable
);
    logic [REGIONS-1:0] idx_match;
    logic [REGIONS-1:0] idx_we;

    // One comparator per region: decode the index and qualify it with the enable.
    for (genvar g = 0; g < REGIONS; g++) begin : g_region
        assign idx_match[g] = (region_idx == SEL_W'(g));
        assign idx_we[g]    = idx_match[g] & region_we_vec[g];
    end

    // Writable if the selected region is enabled, or if no region matches.
    always_comb begin
        region_writable = (|idx_we) | ~(|idx_match);
    end
endmodule

// File: rtl/swp_policy.sv
// Combinational policy: turns the cycle type, the protection state and the
// configuration bits into a verdict for the cycle.
// Assumes the inputs are stable in the clock where cyc_strobe is high.
module swp_policy
    import swp_pkg::*;
(
    input  logic      cyc_strobe,
    input  logic [1:0] cyc_kind,
    input  logic      cyc_from_cpu,
    input  logic      shadow_hit,
    input  logic      region_writable,
    input  logic      cfg_force_wt,
    input  logic      cfg_inval_en,
    output gate_dec_t dec,
    output logic      force_wt
);
    logic is_write;
    logic is_l2wb;
    logic protected_hit;

    // Classify the cycle and the protection state of its target.
    always_comb begin
        is_write      = (cyc_kind == CYC_WRITE);
        is_l2wb       = (cyc_kind == CYC_L2WB);
        protected_hit = shadow_hit & ~region_writable;
    end

    // Verdict. A writeback always writes, and protection blocks the other kinds.
    always_comb begin
        dec.dram_we     = cyc_strobe & (is_l2wb | (is_write & ~protected_hit));
        dec.cache_block = cyc_strobe & ~is_l2wb & protected_hit;
        dec.inval_req   = cyc_strobe & is_write & cyc_from_cpu
                          & protected_hit & cfg_inval_en;
        dec.ready       = cyc_strobe;
    end

    // Write-through request, valid in the strobe clock.
    always_comb begin
        force_wt = cyc_strobe & shadow_hit & cfg_force_wt;
    end
endmodule

// File: rtl/swp_resp_reg.sv
// Response stage: holds the verdict for the one clock after the strobe.
// Assumes a synchronous active-low reset. Every field is a one-clock pulse,
// because a new verdict or an idle verdict is loaded on every edge.
module swp_resp_reg
    import swp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  gate_dec_t dec_d,
    output gate_dec_t dec_q
);
    // Capture the verdict, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end
endmodule

// File: rtl/shadow_wp_gate.sv
// Shadow RAM write-protect gate, the top level.
// Judges every memory cycle against per-region write protection. A dropped
// write still gets a ready. Assumes the address decode (shadow_hit,
// region_idx) is valid in the strobe clock.
module shadow_wp_gate
    import swp_pkg::*;
#(
    parameter int REGIONS = 8,
    localparam int SEL_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_strobe,
    input  logic [1:0]         cyc_kind,
    input  logic               cyc_from_cpu,
    input  logic               shadow_hit,
    input  logic [SEL_W-1:0]   region_idx,
    input  logic [REGIONS-1:0] region_we_vec,
    input  logic               cfg_force_wt,
    input  logic               cfg_inval_en,
    output logic               dram_we,
    output logic               cache_block,
    output logic               cpu_force_wt,
    output logic               cpu_inval_n,
    output logic               cyc_ready
);
    logic      region_writable;
    gate_dec_t dec_d;
    gate_dec_t dec_q;

    swp_region_sel #(.REGIONS(REGIONS)) u_sel (
        .region_idx      (region_idx),
        .region_we_vec   (region_we_vec),
        .region_writable (region_writable)
    );

    swp_policy u_policy (
        .cyc_strobe      (cyc_strobe),
        .cyc_kind        (cyc_kind),
        .cyc_from_cpu    (cyc_from_cpu),
        .shadow_hit      (shadow_hit),
        .region_writable (region_writable),
        .cfg_force_wt    (cfg_force_wt),
        .cfg_inval_en    (cfg_inval_en),
        .dec             (dec_d),
        .force_wt        (cpu_force_wt)
    );

    swp_resp_reg u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_d (dec_d),
        .dec_q (dec_q)
    );

    // Drive the ports from the registered verdict.
    always_comb begin
        dram_we     = dec_q.dram_we;
        cache_block = dec_q.cache_block;
        cyc_ready   = dec_q.ready;
        cpu_inval_n = ~dec_q.inval_req;
    end

    // Set one clock after reset, so that $past never looks at reset-time inputs.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    a_r8_ready_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        chk_armed |-> (cyc_ready == $past(cyc_strobe)));

    a_r4_l2wb_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cyc_strobe && cyc_kind == CYC_L2WB))
        |-> (dram_we && !cache_block));

    a_r2_protected_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cyc_strobe && cyc_kind == CYC_WRITE && shadow_hit
                            && !region_we_vec[region_idx]))
        |-> (!dram_we && cache_block));

    a_r9_unshadowed_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(cyc_strobe && !shadow_hit))
        |-> (!cache_block && cpu_inval_n
             && dram_we == $past(cyc_kind == CYC_WRITE || cyc_kind == CYC_L2WB)));

    a_r6_inval_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !cpu_inval_n)
        |-> $past(cyc_strobe && cyc_kind == CYC_WRITE && cyc_from_cpu && shadow_hit
                  && !region_we_vec[region_idx] && cfg_inval_en));
endmodule

// File: tb/shadow_wp_gate_bench.sv
// Bench for shadow_wp_gate. A behavioural model predicts every output on
// every clock, and the bench compares against it.
module shadow_wp_gate_bench;
    localparam int REGIONS = 8;
    localparam int SEL_W   = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cyc_strobe = 1'b0;
    logic [1:0]         cyc_kind = 2'b00;
    logic               cyc_from_cpu = 1'b0;
    logic               shadow_hit = 1'b0;
    logic [SEL_W-1:0]   region_idx = '0;
    logic [REGIONS-1:0] region_we_vec = '0;
    logic               cfg_force_wt = 1'b0;
    logic               cfg_inval_en = 1'b0;
    logic               dram_we, cache_block, cpu_force_wt, cpu_inval_n, cyc_ready;

    shadow_wp_gate #(.REGIONS(REGIONS)) u_shadow_wp_gate (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .cyc_kind(cyc_kind),
        .cyc_from_cpu(cyc_from_cpu), .shadow_hit(shadow_hit), .region_idx(region_idx),
        .region_we_vec(region_we_vec), .cfg_force_wt(cfg_force_wt),
        .cfg_inval_en(cfg_inval_en), .dram_we(dram_we), .cache_block(cache_block),
        .cpu_force_wt(cpu_force_wt), .cpu_inval_n(cpu_inval_n), .cyc_ready(cyc_ready)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One bus clock: drive at the falling edge, check the same-clock output,
    // let the rising edge pass, then check the registered outputs.
    task automatic cycle(input logic stb, input logic [1:0] k, input logic cpu,
                         input logic hit, input int idx, input logic [REGIONS-1:0] we,
                         input logic wt, input logic inv);
        logic  prot, e_we, e_blk, e_inv_n;
        string tag;
        cyc_strobe = stb; cyc_kind = k; cyc_from_cpu = cpu; shadow_hit = hit;
        region_idx = idx[SEL_W-1:0]; region_we_vec = we;
        cfg_force_wt = wt; cfg_inval_en = inv;
        #1;
        chk("R5", "cpu_force_wt", cpu_force_wt, stb && hit && wt);
        prot = hit && !we[idx];
        e_we = 1'b0; e_blk = 1'b0; e_inv_n = 1'b1;
        if (stb) begin
            if (k == 2'b10) begin
                e_we = 1'b1;
            end else if (k == 2'b01) begin
                if (prot) begin
                    e_blk = 1'b1;
                    if (cpu && inv) e_inv_n = 1'b0;
                end else begin
                    e_we = 1'b1;
                end
            end else begin
                if (prot) e_blk = 1'b1;
            end
        end
        if (!stb)                          tag = "R8";
        else if (k == 2'b10)               tag = "R4";
        else if (!hit)                     tag = "R9";
        else if (k == 2'b01 && !prot)      tag = "R7";
        else if (k == 2'b01 && !cpu)       tag = "R10";
        else if (k == 2'b01)               tag = "R2";
        else if (prot)                     tag = "R3";
        else                               tag = "R8";
        @(posedge clk);
        @(negedge clk);
        chk(tag, "dram_we", dram_we, e_we);
        chk(tag, "cache_block", cache_block, e_blk);
        chk("R8", "cyc_ready", cyc_ready, stb);
        chk(e_inv_n ? tag : "R6", "cpu_inval_n", cpu_inval_n, e_inv_n);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset values, while a strobe is also driven during reset
        @(negedge clk);
        cyc_strobe = 1'b1; cyc_kind = 2'b01; shadow_hit = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "dram_we", dram_we, 1'b0);
        chk("R1", "cache_block", cache_block, 1'b0);
        chk("R1", "cyc_ready", cyc_ready, 1'b0);
        chk("R1", "cpu_inval_n", cpu_inval_n, 1'b1);
        cyc_strobe = 1'b0;
        rst_n = 1'b1;
        // R1: first clock after reset, with no strobe
        cycle(1'b0, 2'b00, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0);

        // R9: unshadowed pass-through, config off and on
        cycle(1'b1, 2'b01, 1'b1, 1'b0, 2, 8'h00, 1'b0, 1'b0);
        cycle(1'b1, 2'b00, 1'b1, 1'b0, 2, 8'h00, 1'b1, 1'b1);
        // R2 / R6: protected processor write, with and without the invalidate enable
        cycle(1'b1, 2'b01, 1'b1, 1'b1, 3, 8'hF7, 1'b0, 1'b0);
        cycle(1'b1, 2'b01, 1'b1, 1'b1, 3, 8'hF7, 1'b1, 1'b1);
        cycle(1'b0, 2'b00, 1'b0, 1'b0, 0, 8'hF7, 1'b1, 1'b1);
        // R6: back-to-back protected writes give one pulse per write
        cycle(1'b1, 2'b01, 1'b1, 1'b1, 0, 8'hFE, 1'b0, 1'b1);
        cycle(1'b1, 2'b01, 1'b1, 1'b1, 0, 8'hFE, 1'b0, 1'b1);
        cycle(1'b1, 2'b00, 1'b1, 1'b1, 0, 8'hFE, 1'b0, 1'b1);
        // R3: protected read blocks the fill, and so does the spare code
        cycle(1'b1, 2'b00, 1'b1, 1'b1, 5, 8'h00, 1'b0, 1'b0);
        cycle(1'b1, 2'b11, 1'b0, 1'b1, 5, 8'h00, 1'b0, 1'b0);
        // R4: writeback into a protected region still writes
        cycle(1'b1, 2'b10, 1'b0, 1'b1, 7, 8'h00, 1'b1, 1'b1);
        // R7: writable write under forced write-through
        cycle(1'b1, 2'b01, 1'b1, 1'b1, 4, 8'h10, 1'b1, 1'b1);
        // R10: protected write from another master, no invalidate
        cycle(1'b1, 2'b01, 1'b0, 1'b1, 6, 8'h00, 1'b0, 1'b1);
        // R5: force-wt needs both the hit and the strobe
        cycle(1'b0, 2'b01, 1'b1, 1'b1, 1, 8'h00, 1'b1, 1'b0);

        // Mixed traffic with random protection and configuration
        for (int i = 0; i < 3000; i++) begin
            cycle(1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                  $urandom_range(0, REGIONS - 1), 8'($urandom),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule